// File: doc/BRIEF.md
# Double-Buffered Serial Register Port

This block is the configuration slave of a larger chip. A host reaches it through a four-wire serial link: an active-low select, a serial clock and a data pin. The data pin works both ways by default. A mode bit moves read data onto a separate output pin. Every write lands in a shadow copy of the target register. The working copy, which the rest of the chip sees on `act_regs`, does not change until a commit event occurs. A commit is either a high level on the update input or any change on the three profile-select inputs. Both inputs are sampled on a divided synchronisation tick that runs at one quarter of the system clock rate. The block outputs that tick as `sync_clk`.

All serial pins are oversampled in the system clock domain. A transaction starts with an instruction byte, followed by the data bits for the addressed register. A dedicated port-reset input aborts a broken transaction and returns the shifter to idle. It also throws away every shadow write made since the last commit, and it leaves the working registers alone.

Top module: `serial_reg_port`

## Requirements
- R1: A transaction sends an 8-bit instruction and then data, both MSB first, sampled on rising edges of `sclk`. Instruction bit 7 selects read (1) or write (0), and bits 4:0 hold the address. Addresses 0 and 1 carry 32 data bits. Addresses 2 and 3 carry 16 data bits.
- R2: A completed write changes no bit of `act_regs` until a commit occurs.
- R3: If `io_update` is high at a synchronisation tick, every shadow register is copied into its working register within 12 system clocks.
- R4: A change of `profile` between two ticks commits all shadow registers and loads `act_profile` with the new value. A steady `profile` commits nothing.
- R5: A read returns the working value of the register, not its pending shadow value. Each bit is driven after a falling edge of `sclk`, MSB first.
- R6: While `cs_n` is high, activity on `sclk` and `sdio_i` has no effect. Raising `cs_n` part-way through a transaction discards that transaction.
- R7: A high on `port_rst` during a transaction returns the shifter to idle. It restores every shadow register to its working value and leaves `act_regs` untouched. The next transaction then works normally.
- R8: In bidirectional mode (working register 0, bit 1 clear), read data appears on `sdio_o` with `sdio_oe` high and `sdo_o` low. With that bit set, read data appears on `sdo_o` and `sdio_oe` stays low.
- R9: After reset, `act_regs`, `sdio_oe` and `sdo_o` are zero, and `sync_clk` has a period of 4 system clocks.
- R10: A write to an address of 4 or more changes no register, and a read from such an address returns zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Active-low select of the serial link |
| sclk | input | 1 | Serial clock from the host |
| sdio_i | input | 1 | Serial data into the block |
| port_rst | input | 1 | Aborts the transaction and discards uncommitted writes |
| io_update | input | 1 | Commit request, sampled at each sync tick |
| profile | input | 3 | Profile select; a change commits |
| sdio_o | output | 1 | Read data on the shared pin |
| sdio_oe | output | 1 | Output enable of the shared pin |
| sdo_o | output | 1 | Read data in unidirectional mode |
| sync_clk | output | 1 | Synchronisation clock, system clock divided by 4 |
| act_regs | output | 128 | Working registers, register n at bits n*32 and up |
| act_profile | output | 3 | Profile value latched at the last profile commit |

## Verification
The bench reads a register while its shadow holds a different pending value. A design that read back the shadow would return the new data before any commit. It also aborts transactions both by raising select and by pulsing port reset mid-word. A design that kept partial shifts, or that committed the discarded shadow on the next update, would corrupt the working registers. Steady profile inputs must not commit anything. A level-triggered profile compare would commit on every tick. Both data-pin modes are checked, so a design that drove both pins or enabled the shared pin in unidirectional mode would be caught. Short 16-bit registers and addresses outside the map cover masking of the instruction bits and decoding of the address.

// File: rtl/rsp_pkg.sv
`timescale 1ns/1ps
package rsp_pkg;
  localparam int ADDR_W  = 5;
  localparam int UNI_BIT = 1;

  typedef enum logic [1:0] {
    ST_INSTR = 2'd0,
    ST_WDATA = 2'd1,
    ST_RDATA = 2'd2,
    ST_DONE  = 2'd3
  } xfer_state_t;

  // Number of data bits carried by the register at address a.
  function automatic int field_bits(input logic [ADDR_W-1:0] a,
                                    input int num_long, input int reg_w);
    return (int'(a) < num_long) ? reg_w : reg_w / 2;
  endfunction
endpackage

// File: rtl/rsp_sync.sv
`timescale 1ns/1ps
module rsp_sync #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta;

  always_ff @(posedge clk) begin
    if (rst) begin
      meta <= '0;
      q    <= '0;
    end else begin
      meta <= d;
      q    <= meta;
    end
  end
endmodule

// File: rtl/rsp_shifter.sv
`timescale 1ns/1ps
module rsp_shifter
  import rsp_pkg::*;
#(
  parameter int NUM_LONG = 2,
  parameter int REG_W    = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clear,
  input  logic              sclk_s,
  input  logic              sdi_s,
  input  logic [REG_W-1:0]  rd_data,
  output logic [ADDR_W-1:0] rd_addr,
  output logic              wr_en,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [REG_W-1:0]  wr_data,
  output logic              out_bit,
  output logic              rd_active
);
  localparam int CW = $clog2(REG_W) + 1;

  xfer_state_t       st;
  logic              sclk_q;
  logic [REG_W-2:0]  sr;
  logic [REG_W-1:0]  rdsh;
  logic [CW-1:0]     cnt;
  logic [CW-1:0]     nbits;
  logic [ADDR_W-1:0] addr_q;

  logic              rise, fall;
  logic [REG_W-1:0]  data_nx;
  logic [7:0]        instr_nx;
  logic [CW-1:0]     nb;
  logic [REG_W-1:0]  mask;

  assign rise      = sclk_s & ~sclk_q;
  assign fall      = ~sclk_s & sclk_q;
  assign data_nx   = {sr, sdi_s};
  assign instr_nx  = data_nx[7:0];
  assign rd_addr   = instr_nx[ADDR_W-1:0];
  assign nb        = CW'(field_bits(rd_addr, NUM_LONG, REG_W));
  assign mask      = (nbits == CW'(REG_W)) ? '1 : ((REG_W'(1) << nbits) - REG_W'(1));
  assign rd_active = (st == ST_RDATA);

  always_ff @(posedge clk) begin
    if (rst) sclk_q <= 1'b0;
    else     sclk_q <= sclk_s;
  end

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      st      <= ST_INSTR;
      cnt     <= '0;
      out_bit <= 1'b0;
      wr_en   <= 1'b0;
    end else begin
      wr_en <= 1'b0;
      case (st)
        ST_INSTR: if (rise) begin
          sr <= data_nx[REG_W-2:0];
          if (cnt == CW'(7)) begin
            cnt    <= '0;
            addr_q <= rd_addr;
            nbits  <= nb;
            if (instr_nx[7]) begin
              st   <= ST_RDATA;
              rdsh <= rd_data << (REG_W - int'(nb));
            end else begin
              st <= ST_WDATA;
            end
          end else begin
            cnt <= cnt + CW'(1);
          end
        end
        ST_WDATA: if (rise) begin
          sr <= data_nx[REG_W-2:0];
          if (cnt == nbits - CW'(1)) begin
            wr_en   <= 1'b1;
            wr_addr <= addr_q;
            wr_data <= data_nx & mask;
            st      <= ST_DONE;
          end else begin
            cnt <= cnt + CW'(1);
          end
        end
        ST_RDATA: begin
          if (fall) begin
            out_bit <= rdsh[REG_W-1];
            rdsh    <= rdsh << 1;
          end
          if (rise) begin
            if (cnt == nbits - CW'(1)) st <= ST_DONE;
            else                       cnt <= cnt + CW'(1);
          end
        end
        default: out_bit <= 1'b0;
      endcase
    end
  end
endmodule

// File: rtl/rsp_regbank.sv
`timescale 1ns/1ps
module rsp_regbank
  import rsp_pkg::*;
#(
  parameter int NUM_REGS = 4,
  parameter int REG_W    = 32
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      wr_en,
  input  logic [ADDR_W-1:0]         wr_addr,
  input  logic [REG_W-1:0]          wr_data,
  input  logic                      commit,
  input  logic                      discard,
  input  logic [ADDR_W-1:0]         rd_addr,
  output logic [REG_W-1:0]          rd_data,
  output logic [NUM_REGS*REG_W-1:0] act_flat
);
  logic [NUM_REGS-1:0][REG_W-1:0] act_v;

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
    logic [REG_W-1:0] shadow_q;
    logic [REG_W-1:0] work_q;

    always_ff @(posedge clk) begin
      if (rst)                                    shadow_q <= '0;
      else if (discard)                           shadow_q <= work_q;
      else if (wr_en && wr_addr == ADDR_W'(g))    shadow_q <= wr_data;
    end

    always_ff @(posedge clk) begin
      if (rst)         work_q <= '0;
      else if (commit) work_q <= shadow_q;
    end

    assign act_v[g] = work_q;
  end

  always_comb begin
    rd_data = '0;
    for (int i = 0; i < NUM_REGS; i++)
      if (rd_addr == ADDR_W'(i)) rd_data = act_v[i];
  end

  assign act_flat = act_v;
endmodule

// File: rtl/rsp_update_ctl.sv
`timescale 1ns/1ps
module rsp_update_ctl #(
  parameter int PROF_W = 3,
  parameter int DIV    = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              upd_s,
  input  logic [PROF_W-1:0] prof_s,
  output logic              sync_clk,
  output logic              xfer,
  output logic [PROF_W-1:0] act_profile
);
  localparam int DW = (DIV > 2) ? $clog2(DIV) : 1;

  logic [DW-1:0]     dcnt;
  logic [PROF_W-1:0] prof_hold;
  logic              tick;

  assign tick = (dcnt == DW'(DIV - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      dcnt        <= '0;
      sync_clk    <= 1'b0;
      xfer        <= 1'b0;
      prof_hold   <= '0;
      act_profile <= '0;
    end else begin
      dcnt     <= tick ? '0 : dcnt + DW'(1);
      sync_clk <= (dcnt < DW'(DIV / 2));
      xfer     <= 1'b0;
      if (tick) begin
        prof_hold <= prof_s;
        if (upd_s || (prof_s != prof_hold)) begin
          xfer        <= 1'b1;
          act_profile <= prof_s;
        end
      end
    end
  end
endmodule

// File: rtl/serial_reg_port.sv
`timescale 1ns/1ps
module serial_reg_port
  import rsp_pkg::*;
#(
  parameter int NUM_REGS = 4,
  parameter int NUM_LONG = 2,
  parameter int REG_W    = 32,
  parameter int PROF_W   = 3,
  parameter int SYNC_DIV = 4
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      cs_n,
  input  logic                      sclk,
  input  logic                      sdio_i,
  input  logic                      port_rst,
  input  logic                      io_update,
  input  logic [PROF_W-1:0]         profile,
  output logic                      sdio_o,
  output logic                      sdio_oe,
  output logic                      sdo_o,
  output logic                      sync_clk,
  output logic [NUM_REGS*REG_W-1:0] act_regs,
  output logic [PROF_W-1:0]         act_profile
);
  localparam int SW = 5 + PROF_W;

  logic [SW-1:0]     raw, syn;
  logic              cs_hi, sclk_s, sdi_s, prst_s, upd_s;
  logic [PROF_W-1:0] prof_s;

  logic [ADDR_W-1:0] rd_addr, wr_addr;
  logic [REG_W-1:0]  rd_data, wr_data;
  logic              wr_en, out_bit, rd_active;
  logic              xfer, commit, uni;

  assign raw = {cs_n, sclk, sdio_i, port_rst, io_update, profile};

  rsp_sync #(.W(SW)) u_sync (.clk(clk), .rst(rst), .d(raw), .q(syn));

  assign {cs_hi, sclk_s, sdi_s, prst_s, upd_s, prof_s} = syn;

  rsp_shifter #(.NUM_LONG(NUM_LONG), .REG_W(REG_W)) u_shift (
    .clk(clk), .rst(rst), .clear(cs_hi | prst_s),
    .sclk_s(sclk_s), .sdi_s(sdi_s), .rd_data(rd_data), .rd_addr(rd_addr),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .out_bit(out_bit), .rd_active(rd_active)
  );

  rsp_update_ctl #(.PROF_W(PROF_W), .DIV(SYNC_DIV)) u_upd (
    .clk(clk), .rst(rst), .upd_s(upd_s), .prof_s(prof_s),
    .sync_clk(sync_clk), .xfer(xfer), .act_profile(act_profile)
  );

  assign commit = xfer & ~prst_s;

  rsp_regbank #(.NUM_REGS(NUM_REGS), .REG_W(REG_W)) u_bank (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .commit(commit), .discard(prst_s), .rd_addr(rd_addr), .rd_data(rd_data),
    .act_flat(act_regs)
  );

  assign uni = act_regs[UNI_BIT];

  always_ff @(posedge clk) begin
    if (rst) begin
      sdio_o  <= 1'b0;
      sdio_oe <= 1'b0;
      sdo_o   <= 1'b0;
    end else begin
      sdio_o  <= ~uni & out_bit;
      sdio_oe <= rd_active & ~uni & ~cs_hi;
      sdo_o   <= uni & rd_active & out_bit;
    end
  end
endmodule

// File: rtl/serial_reg_port_chk.sv
`timescale 1ns/1ps
module serial_reg_port_chk #(
  parameter int NUM_REGS = 4,
  parameter int REG_W    = 32
) (
  input logic                      clk,
  input logic                      rst,
  input logic                      cs_hi,
  input logic                      prst_s,
  input logic                      xfer,
  input logic                      commit,
  input logic                      sdio_oe,
  input logic                      sdo_o,
  input logic [NUM_REGS*REG_W-1:0] act_regs
);
  assert_hold_until_commit_R2: assert property (@(posedge clk) disable iff (rst)
    !commit |=> $stable(act_regs));

  assert_single_xfer_pulse_R3: assert property (@(posedge clk) disable iff (rst)
    xfer |=> !xfer);

  assert_deselect_quiet_R6: assert property (@(posedge clk) disable iff (rst)
    cs_hi |=> !sdio_oe);

  assert_port_reset_keeps_R7: assert property (@(posedge clk) disable iff (rst)
    prst_s |=> $stable(act_regs));

  assert_port_reset_release_R7: assert property (@(posedge clk) disable iff (rst)
    prst_s |=> ##1 !sdio_oe);

  assert_pins_exclusive_R8: assert property (@(posedge clk) disable iff (rst)
    sdio_oe |-> (sdo_o == 1'b0));
endmodule

bind serial_reg_port serial_reg_port_chk #(.NUM_REGS(NUM_REGS), .REG_W(REG_W)) u_chk (
  .clk(clk), .rst(rst), .cs_hi(cs_hi), .prst_s(prst_s), .xfer(xfer),
  .commit(commit), .sdio_oe(sdio_oe), .sdo_o(sdo_o), .act_regs(act_regs)
);

// File: tb/serial_reg_port_bench.sv
`timescale 1ns/1ps
module serial_reg_port_bench;
  localparam int NR   = 4;
  localparam int RW   = 32;
  localparam int HALF = 8;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic          rst = 1'b1;
  logic          cs_n = 1'b1, sclk = 1'b0, sdio_i = 1'b0;
  logic          port_rst = 1'b0, io_update = 1'b0;
  logic [2:0]    profile = 3'd0;
  logic          sdio_o, sdio_oe, sdo_o, sync_clk;
  logic [NR*RW-1:0] act_regs;
  logic [2:0]    act_profile;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  serial_reg_port u_serial_reg_port (
    .clk(clk), .rst(rst), .cs_n(cs_n), .sclk(sclk), .sdio_i(sdio_i),
    .port_rst(port_rst), .io_update(io_update), .profile(profile),
    .sdio_o(sdio_o), .sdio_oe(sdio_oe), .sdo_o(sdo_o), .sync_clk(sync_clk),
    .act_regs(act_regs), .act_profile(act_profile)
  );

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input string what,
                     input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, got, exp);
    end
  endtask

  function automatic logic [31:0] areg(input int i);
    return act_regs[i*RW +: RW];
  endfunction

  task automatic send_bit(input logic b);
    sclk = 1'b0; sdio_i = b; tick(HALF);
    sclk = 1'b1; tick(HALF);
  endtask

  task automatic xact_end();
    sclk = 1'b0; tick(HALF);
    cs_n = 1'b1; tick(2*HALF);
  endtask

  task automatic spi_write(input logic [4:0] a, input logic [31:0] d, input int nb);
    logic [7:0] ins;
    ins = {3'b000, a};
    cs_n = 1'b0; tick(HALF);
    for (int i = 7; i >= 0; i--) send_bit(ins[i]);
    for (int i = nb*8-1; i >= 0; i--) send_bit(d[i]);
    xact_end();
  endtask

  task automatic spi_read(input logic [4:0] a, input int nb, input bit uni,
                          output logic [31:0] d, output int oe_bad);
    logic [7:0] ins;
    ins = {3'b100, a};
    d = '0; oe_bad = 0;
    cs_n = 1'b0; tick(HALF);
    for (int i = 7; i >= 0; i--) send_bit(ins[i]);
    for (int i = nb*8-1; i >= 0; i--) begin
      sclk = 1'b0; tick(HALF);
      d[i] = uni ? sdo_o : sdio_o;
      if (sdio_oe !== !uni) oe_bad++;
      if (!uni && sdo_o !== 1'b0) oe_bad++;
      sclk = 1'b1; tick(HALF);
    end
    xact_end();
  endtask

  task automatic pulse_update();
    io_update = 1'b1; tick(8);
    io_update = 1'b0; tick(12);
  endtask

  task automatic t_reset();
    int n;
    for (int i = 0; i < NR; i++) chk("R9", "reset register", areg(i), 32'h0);
    chk("R9", "reset sdio_oe", {31'h0, sdio_oe}, 32'h0);
    chk("R9", "reset sdo_o", {31'h0, sdo_o}, 32'h0);
    while (sync_clk !== 1'b0) tick(1);
    while (sync_clk !== 1'b1) tick(1);
    n = 0;
    while (sync_clk !== 1'b0) begin tick(1); n++; end
    while (sync_clk !== 1'b1) begin tick(1); n++; end
    chk("R9", "sync_clk period", n, 32'd4);
  endtask

  task automatic t_write_commit();
    logic [31:0] d; int bad;
    spi_write(5'd1, 32'hA5C3_0F12, 4);
    tick(40);
    chk("R2", "reg1 before commit", areg(1), 32'h0);
    spi_read(5'd1, 4, 1'b0, d, bad);
    chk("R5", "read returns working value", d, 32'h0);
    pulse_update();
    chk("R3", "reg1 after update", areg(1), 32'hA5C3_0F12);
    chk("R1", "32-bit write reg0 untouched", areg(0), 32'h0);
    spi_read(5'd1, 4, 1'b0, d, bad);
    chk("R5", "read after commit", d, 32'hA5C3_0F12);
    chk("R8", "bidirectional pin enables", bad, 32'd0);
  endtask

  task automatic t_profile();
    spi_write(5'd2, 32'h0000_BEEF, 2);
    spi_write(5'd3, 32'h0000_1234, 2);
    tick(20);
    chk("R2", "reg2 before profile change", areg(2), 32'h0);
    profile = 3'd5; tick(16);
    chk("R4", "reg2 after profile change", areg(2), 32'h0000_BEEF);
    chk("R1", "16-bit write reg3", areg(3), 32'h0000_1234);
    chk("R4", "act_profile", {29'h0, act_profile}, 32'd5);
    spi_write(5'd3, 32'h0000_5555, 2);
    tick(60);
    chk("R4", "steady profile no commit", areg(3), 32'h0000_1234);
  endtask

  task automatic t_cs_ignore();
    logic [7:0] ins;
    for (int i = 0; i < 40; i++) send_bit(i[0]);
    sclk = 1'b0; tick(HALF);
    ins = 8'h02;
    cs_n = 1'b0; tick(HALF);
    for (int i = 7; i >= 0; i--) send_bit(ins[i]);
    for (int i = 0; i < 8; i++) send_bit(1'b1);
    xact_end();
    pulse_update();
    chk("R6", "reg1 after deselected traffic", areg(1), 32'hA5C3_0F12);
    chk("R6", "reg2 after aborted write", areg(2), 32'h0000_BEEF);
    chk("R3", "pending reg3 committed", areg(3), 32'h0000_5555);
  endtask

  task automatic t_port_reset();
    logic [7:0] ins;
    spi_write(5'd2, 32'h0000_7777, 2);
    ins = 8'h01;
    cs_n = 1'b0; tick(HALF);
    for (int i = 7; i >= 0; i--) send_bit(ins[i]);
    for (int i = 0; i < 12; i++) send_bit(1'b0);
    port_rst = 1'b1; tick(8);
    sclk = 1'b0; cs_n = 1'b1; tick(2);
    port_rst = 1'b0; tick(16);
    chk("R7", "reg1 intact after port reset", areg(1), 32'hA5C3_0F12);
    chk("R7", "reg2 intact after port reset", areg(2), 32'h0000_BEEF);
    pulse_update();
    chk("R7", "discarded shadow not committed", areg(2), 32'h0000_BEEF);
    chk("R7", "reg1 after commit", areg(1), 32'hA5C3_0F12);
    spi_write(5'd2, 32'h0000_4242, 2);
    pulse_update();
    chk("R7", "write after port reset", areg(2), 32'h0000_4242);
  endtask

  task automatic t_invalid();
    logic [31:0] d; int bad;
    spi_write(5'd5, 32'h0000_FFFF, 2);
    pulse_update();
    chk("R10", "reg0 after bad address", areg(0), 32'h0);
    chk("R10", "reg1 after bad address", areg(1), 32'hA5C3_0F12);
    chk("R10", "reg2 after bad address", areg(2), 32'h0000_4242);
    chk("R10", "reg3 after bad address", areg(3), 32'h0000_5555);
    spi_read(5'd7, 2, 1'b0, d, bad);
    chk("R10", "read bad address", d, 32'h0);
  endtask

  task automatic t_unidir();
    logic [31:0] d; int bad;
    spi_write(5'd0, 32'h0000_0002, 4);
    pulse_update();
    chk("R1", "mode register", areg(0), 32'h0000_0002);
    spi_read(5'd1, 4, 1'b1, d, bad);
    chk("R8", "unidirectional read on sdo_o", d, 32'hA5C3_0F12);
    chk("R8", "shared pin stays off", bad, 32'd0);
    spi_read(5'd3, 2, 1'b1, d, bad);
    chk("R8", "unidirectional short read", d, 32'h0000_5555);
  endtask

  initial begin
    tick(6);
    rst = 1'b0;
    tick(4);
    t_reset();
    t_write_commit();
    t_profile();
    t_cs_ignore();
    t_port_reset();
    t_invalid();
    t_unidir();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule